// File: doc/BRIEF.md
# Glitch-Free Output Freeze Controller

This block generates two banks of divided clocks from one fast reference clock: five bus-clock outputs and seven peripheral-clock outputs. Each bank has its own two-bit ratio select. Any single output can be parked low through a three-wire serial port, which has a data line, a shift clock and a commit strobe. One common freeze pin parks every output at once. A parked output stops toggling, but its divider keeps counting. When the output is released it therefore lines up with the outputs that were never parked.

Entry to and exit from the parked state happen only while the bank's divided level is low. This means no shortened high pulse can appear on any output. An active-low master reset pin clears all internal state and floats every output. A bypass pin makes the dividers advance on rising edges of a slow test clock instead of on every reference cycle.

All control inputs pass through two-flop synchronisers into the reference domain. The master reset is sampled synchronously, but the high-impedance control follows that pin directly.

Top module: `clk_freeze_ctl`

## Requirements
- R1: Serial bits are taken on rising edges of the shift clock, most significant bit first, into a 12-bit shifter. A rising edge of the strobe copies the shifter into the active freeze word. Bit i (0..4) controls bus_clk[i], bit 5+j (0..6) controls per_clk[j], and a 1 means parked.
- R2: While the common freeze pin is high, every output is parked whatever the freeze word holds. After the pin drops, the freeze word alone decides again.
- R3: A parked output stays at a constant low level.
- R4: A change of parked state takes effect only while the bank's divided level is low. Every active output of a bank is equal to every other active output of that bank at all times, including one just released.
- R5: Bank select value n gives an output period of 2(n+1) reference cycles (ratios 2, 4, 6, 8). The dividers keep counting while outputs are parked.
- R6: Right after reset is released all outputs are low, the freeze word is clear, and every output toggles.
- R7: While mr_n is low all outputs are high impedance, and on release all state, including the freeze word, is cleared.
- R8: With bypass high, the dividers advance once per synchronised rising edge of tclk. An output first rises after n+1 tclk rising edges following reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| mr_n | input | 1 | Active-low master reset and output float |
| bypass | input | 1 | Divider step source: 1 = tclk edges, 0 = every cycle (static) |
| tclk | input | 1 | Test clock used in bypass |
| bus_sel | input | 2 | Bus bank ratio select |
| per_sel | input | 2 | Peripheral bank ratio select |
| frz_data | input | 1 | Serial freeze data |
| frz_sclk | input | 1 | Serial shift clock |
| frz_strobe | input | 1 | Commit strobe |
| frz_all | input | 1 | Common freeze |
| bus_clk | output | 5 | Bus-clock outputs |
| per_clk | output | 7 | Peripheral-clock outputs |

## Verification
The assertions assume that the bypass pin and both ratio selects are static inputs. The stimulus changes them only during reset or well before any measurement. The assertions also assume that frz_data is stable around each shift-clock edge. The bench holds every serial wire for several reference cycles per phase, so each value crosses the two-flop synchronisers intact, and it also holds the data line steady through every shift-clock edge. The bench toggles tclk only while bypass is high, and it keeps each tclk level for six cycles so that every edge is seen once.

// File: rtl/fcz_pkg.sv
package fcz_pkg;
    localparam int NBUS_DEF = 5;
    localparam int NPER_DEF = 7;
    localparam int SELW_DEF = 2;

    // Synchronised control lines, one field per asynchronous input
    typedef struct packed {
        logic data;
        logic sclk;
        logic strobe;
        logic all;
        logic tclk;
    } ctl_t;

    localparam int CTLW = $bits(ctl_t);

    // Number of steps the divided level stays low (and high) for a select
    function automatic logic [SELW_DEF+1:0] half_of(input logic [SELW_DEF-1:0] sel);
        return {2'b00, sel} + 1'b1;
    endfunction
endpackage

// File: rtl/fcz_sync2.sv
module fcz_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fcz_serial.sv
module fcz_serial #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         data,
    input  logic         sclk,
    input  logic         strobe,
    output logic [N-1:0] word
);
    logic [N-1:0] shifter;
    logic         sclk_d, strobe_d;
    logic         shift_en, commit_en;

    assign shift_en  = sclk & ~sclk_d;
    assign commit_en = strobe & ~strobe_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            shifter  <= '0;
            word     <= '0;
            sclk_d   <= 1'b0;
            strobe_d <= 1'b0;
        end else begin
            sclk_d   <= sclk;
            strobe_d <= strobe;
            if (shift_en)
                shifter <= {shifter[N-2:0], data};
            if (commit_en)
                word <= shifter;
        end
    end
endmodule

// File: rtl/fcz_div.sv
module fcz_div #(
    parameter int SELW = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [SELW-1:0] sel,
    output logic            lvl
);
    localparam int CW = SELW + 2;

    logic [CW-1:0] cnt;
    logic [CW-1:0] half, last;

    assign half = {{(CW-SELW){1'b0}}, sel} + 1'b1;
    assign last = (half << 1) - 1'b1;
    assign lvl  = (cnt >= half);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt >= last) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/fcz_gate.sv
module fcz_gate #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         lvl,
    input  logic [N-1:0] req,
    output logic [N-1:0] fz,
    output logic [N-1:0] out
);
    // Park state may only move while the divided level is low
    always_ff @(posedge clk) begin
        if (rst)
            fz <= '0;
        else if (!lvl)
            fz <= req;
    end

    assign out = {N{lvl}} & ~fz;
endmodule

// File: rtl/clk_freeze_ctl.sv
module clk_freeze_ctl
    import fcz_pkg::*;
#(
    parameter int NBUS = NBUS_DEF,
    parameter int NPER = NPER_DEF,
    parameter int SELW = SELW_DEF
) (
    input  logic            clk,
    input  logic            mr_n,
    input  logic            bypass,
    input  logic            tclk,
    input  logic [SELW-1:0] bus_sel,
    input  logic [SELW-1:0] per_sel,
    input  logic            frz_data,
    input  logic            frz_sclk,
    input  logic            frz_strobe,
    input  logic            frz_all,
    output logic [NBUS-1:0] bus_clk,
    output logic [NPER-1:0] per_clk
);
    localparam int NOUT = NBUS + NPER;

    logic            rst;
    ctl_t            ctl_raw, ctl_s;
    logic            tclk_d, tick, all_s;
    logic [NOUT-1:0] want, req;
    logic            bus_lvl, per_lvl;
    logic [NBUS-1:0] bus_fz, bus_out;
    logic [NPER-1:0] per_fz, per_out;

    assign rst = ~mr_n;

    assign ctl_raw = '{data: frz_data, sclk: frz_sclk, strobe: frz_strobe,
                       all: frz_all, tclk: tclk};

    fcz_sync2 #(.W(CTLW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    always_ff @(posedge clk) begin
        if (rst) tclk_d <= 1'b0;
        else     tclk_d <= ctl_s.tclk;
    end

    assign tick  = bypass ? (ctl_s.tclk & ~tclk_d) : 1'b1;
    assign all_s = ctl_s.all;

    fcz_serial #(.N(NOUT)) u_serial (
        .clk    (clk),
        .rst    (rst),
        .data   (ctl_s.data),
        .sclk   (ctl_s.sclk),
        .strobe (ctl_s.strobe),
        .word   (want)
    );

    assign req = want | {NOUT{all_s}};

    fcz_div #(.SELW(SELW)) u_bus_div (
        .clk (clk), .rst (rst), .tick (tick), .sel (bus_sel), .lvl (bus_lvl)
    );

    fcz_div #(.SELW(SELW)) u_per_div (
        .clk (clk), .rst (rst), .tick (tick), .sel (per_sel), .lvl (per_lvl)
    );

    fcz_gate #(.N(NBUS)) u_bus_gate (
        .clk (clk), .rst (rst), .lvl (bus_lvl),
        .req (req[NBUS-1:0]), .fz (bus_fz), .out (bus_out)
    );

    fcz_gate #(.N(NPER)) u_per_gate (
        .clk (clk), .rst (rst), .lvl (per_lvl),
        .req (req[NOUT-1:NBUS]), .fz (per_fz), .out (per_out)
    );

    // Output float follows the pin directly
    generate
        for (genvar i = 0; i < NBUS; i++) begin : g_bus_drv
            assign bus_clk[i] = mr_n ? bus_out[i] : 1'bz;
        end
        for (genvar j = 0; j < NPER; j++) begin : g_per_drv
            assign per_clk[j] = mr_n ? per_out[j] : 1'bz;
        end
    endgenerate
endmodule

// File: rtl/fcz_chk.sv
module fcz_chk #(
    parameter int NBUS = 5,
    parameter int NPER = 7
) (
    input logic            clk,
    input logic            mr_n,
    input logic            all_s,
    input logic            bus_lvl,
    input logic            per_lvl,
    input logic [NBUS-1:0] bus_fz,
    input logic [NPER-1:0] per_fz,
    input logic [NBUS-1:0] bus_out,
    input logic [NPER-1:0] per_out
);
    p_common_bus_r2: assert property (@(posedge clk) disable iff (!mr_n)
        (all_s && !bus_lvl) |=> (&bus_fz));
    p_common_per_r2: assert property (@(posedge clk) disable iff (!mr_n)
        (all_s && !per_lvl) |=> (&per_fz));

    p_bus_change_low_r4: assert property (@(posedge clk) disable iff (!mr_n)
        !$stable(bus_fz) |-> !$past(bus_lvl));
    p_per_change_low_r4: assert property (@(posedge clk) disable iff (!mr_n)
        !$stable(per_fz) |-> !$past(per_lvl));

    p_low_at_release_r6: assert property (@(posedge clk)
        $rose(mr_n) |-> (bus_out == '0 && per_out == '0));

    p_cleared_after_reset_r7: assert property (@(posedge clk) disable iff (!mr_n)
        $past(!mr_n) |-> (bus_fz == '0 && per_fz == '0));
endmodule

bind clk_freeze_ctl fcz_chk #(.NBUS(NBUS), .NPER(NPER)) u_chk (
    .clk     (clk),
    .mr_n    (mr_n),
    .all_s   (all_s),
    .bus_lvl (bus_lvl),
    .per_lvl (per_lvl),
    .bus_fz  (bus_fz),
    .per_fz  (per_fz),
    .bus_out (bus_out),
    .per_out (per_out)
);

// File: tb/clk_freeze_ctl_tb.sv
module clk_freeze_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NBUS = 5;
    localparam int NPER = 7;
    localparam int NOUT = NBUS + NPER;

    logic            clk = 0;
    logic            mr_n = 0, bypass = 0, tclk = 0;
    logic [1:0]      bus_sel = 2'd1, per_sel = 2'd3;
    logic            frz_data = 0, frz_sclk = 0, frz_strobe = 0, frz_all = 0;
    wire  [NBUS-1:0] bus_clk;
    wire  [NPER-1:0] per_clk;

    int n_checks = 0, n_fail = 0;
    logic [NOUT-1:0] exp_q[$];
    string           tag_q[$];
    logic            mon_busy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_freeze_ctl u_dut (
        .clk(clk), .mr_n(mr_n), .bypass(bypass), .tclk(tclk),
        .bus_sel(bus_sel), .per_sel(per_sel),
        .frz_data(frz_data), .frz_sclk(frz_sclk), .frz_strobe(frz_strobe),
        .frz_all(frz_all), .bus_clk(bus_clk), .per_clk(per_clk)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: shift a word MSB first, then strobe
    task automatic load(input logic [NOUT-1:0] w);
        for (int i = NOUT-1; i >= 0; i--) begin
            frz_data = w[i];
            cyc(4); frz_sclk = 1; cyc(4); frz_sclk = 0; cyc(4);
        end
        frz_strobe = 1; cyc(4); frz_strobe = 0; cyc(4);
    endtask

    task automatic expect_mask(input logic [NOUT-1:0] m, input string tag);
        cyc(12);
        exp_q.push_back(m);
        tag_q.push_back(tag);
        cyc(1);
        wait (exp_q.size() == 0 && !mon_busy);
    endtask

    // Monitor: observe 24 cycles per expected mask
    initial begin
        forever begin
            logic [NOUT-1:0] m, seen;
            string tag;
            int phase_bad;
            wait (exp_q.size() > 0);
            mon_busy = 1;
            m = exp_q.pop_front();
            tag = tag_q.pop_front();
            seen = '0;
            phase_bad = 0;
            for (int k = 0; k < 24; k++) begin
                @(negedge clk);
                seen |= {per_clk, bus_clk};
                if (!(((bus_clk & ~m[NBUS-1:0]) == '0) ||
                      ((bus_clk | m[NBUS-1:0]) == '1))) phase_bad++;
                if (!(((per_clk & ~m[NOUT-1:NBUS]) == '0) ||
                      ((per_clk | m[NOUT-1:NBUS]) == '1))) phase_bad++;
            end
            check(seen == ~m, tag, "R3 toggling outputs vs park mask",
                  32'(seen), 32'(~m));
            check(phase_bad == 0, "R4", "active outputs in phase", phase_bad, 0);
            mon_busy = 0;
        end
    end

    task automatic measure(input logic [1:0] sel);
        logic prev;
        int n;
        bus_sel = sel;
        cyc(20);
        prev = bus_clk[0];
        cyc(1);
        while (!(prev == 0 && bus_clk[0] == 1)) begin prev = bus_clk[0]; cyc(1); end
        n = 0;
        prev = bus_clk[0];
        do begin prev = bus_clk[0]; cyc(1); n++; end
        while (!(prev == 0 && bus_clk[0] == 1) && n < 40);
        check(n == 2*(sel+1), "R5", "bus period", n, 2*(sel+1));
    endtask

    initial begin
        int limit = 200000;
        repeat (limit) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        cyc(3);
        check(bus_clk === 5'bz, "R7", "bus float in reset", 32'(bus_clk), 32'h0);
        check(per_clk === 7'bz, "R7", "per float in reset", 32'(per_clk), 32'h0);
        mr_n = 1;
        @(negedge clk);
        check({per_clk, bus_clk} === '0, "R6", "low after release",
              32'({per_clk, bus_clk}), 0);
        expect_mask('0, "R6");

        // R1: single outputs and mixed patterns
        load(12'b0000_0000_0010); expect_mask(12'b0000_0000_0010, "R1");
        load(12'b1010_0100_0001); expect_mask(12'b1010_0100_0001, "R1");
        load(12'b0000_0000_0000); expect_mask('0, "R1");

        // R2: common freeze overrides, then word applies again
        load(12'b0000_0110_0000);
        frz_all = 1; expect_mask('1, "R2");
        frz_all = 0; expect_mask(12'b0000_0110_0000, "R2");

        // R5: ratios
        for (int s = 0; s < 4; s++) measure(2'(s));
        bus_sel = 2'd1;

        // R7: reset mid-run clears the word
        load(12'b1111_0000_1111); expect_mask(12'b1111_0000_1111, "R1");
        @(negedge clk); mr_n = 0; cyc(2);
        check(bus_clk === 5'bz, "R7", "float mid-run", 32'(bus_clk), 0);
        mr_n = 1;
        expect_mask('0, "R7");

        // R8: bypass stepping with select 2
        mr_n = 0; bypass = 1; bus_sel = 2'd2; cyc(3);
        mr_n = 1; cyc(2);
        for (int r = 1; r <= 4; r++) begin
            tclk = 1; cyc(6);
            if (r <= 3)
                check(bus_clk[0] == (r == 3), "R8", "bypass first rise",
                      32'(bus_clk[0]), 32'(r == 3));
            tclk = 0; cyc(6);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule